// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

This block gathers a set of level-sensitive interrupt sources, grouped in banks of 32, and presents them to a processor through a single interrupt line and a small 32-bit register bus. Each source has three bits of state: a pending flag, an enable, and a mask. Pending flags record raised inputs whether or not the source is enabled. A source counts as active when it is pending, enabled and not masked. The interrupt line is high whenever any source is active.

Software reads a vector register to learn which active source to service. The register returns the lowest-numbered active source among sources 1 and up, shifted left by two. A value of zero means there is nothing to service. A handler reads the vector, services that source, clears its pending bit by writing a one to it, and reads the vector again until it returns zero.

A protection register can restrict all register writes to privileged bus accesses. A small control register holds the source-type setting of the external non-maskable input.

Top module: `vic_top`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Source n maps to bank n/32, bit n%32. An input held high at a rising clock edge sets that source's pending bit whatever its enable and mask. The bit stays set after the input drops, until software clears it.
- R3: Writing the pending register of bank b (offset 0x10+4b) clears the bits written as one and leaves the bits written as zero unchanged. A bit whose input is still high stays set after the clear.
- R4: The enable register of bank b (offset 0x40+4b) resets to zero. A zero enable bit keeps its source out of `irq_o` and the vector, but the source still records pending. Setting the enable bit again restores the source.
- R5: The mask register of bank b (offset 0x50+4b) resets to zero. A mask bit of one keeps its source out of `irq_o` and the vector.
- R6: The vector register (offset 0x00) holds the lowest-numbered active source in the range 1 to N-1 in bits [31:2], with bits [1:0] at zero. It reads zero when no source in that range is active.
- R7: Source 0 can become active and raise `irq_o`, but it never appears in the vector.
- R8: `irq_o` is high exactly when at least one source is active.
- R9: The protection register (offset 0x08) keeps bit 0. While that bit is set, a write without `bus_priv_i` changes no register, and this includes the protection register itself. A privileged write still takes effect. While the bit is clear, `bus_priv_i` has no effect.
- R10: The external-input type register (offset 0x0c) keeps the low NMI_W bits written to it and reads zero above them.
- R11: The following addresses read zero and ignore writes:
  - The fast-interrupt pending registers (offset 0x20+4b).
  - Unused offsets.
  - Bank offsets beyond the last bank.
  - The vector register, for writes.
- R12: The vector is computed from present state without a register stage. A read in the cycle after a pending clear already shows the next active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_BANKS*BANK_W | Level interrupt inputs, active high |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 8 | Byte address of the register, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_priv_i | input | 1 | The current access is privileged |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: three banks of 32 sources and a two-bit external-type field. At that size every source number, every bank offset and the invalid fourth bank slot can all be exercised.

The bench raises each of sources 95 down to 1 in turn and checks after each one that the newest, lowest source wins the vector. It then drains all 95 pending sources in ascending order through write-one-to-clear, one cycle per source. Expected vectors and bank images come from the source number by arithmetic. The bench also covers gating, protection and the unmapped addresses with directed patterns.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_VEC,
        RK_PROT,
        RK_NMI,
        RK_PEND,
        RK_FIQ,
        RK_EN,
        RK_MSK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] bank;
    } reg_sel_t;

    // Word-aligned decode; the bank slot sits in address bits [3:2].
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.bank = a[3:2];
        if (a[1:0] == 2'b00) begin
            case (a[7:4])
                4'h0: begin
                    case (a[3:2])
                        2'd0:    s.kind = RK_VEC;
                        2'd2:    s.kind = RK_PROT;
                        2'd3:    s.kind = RK_NMI;
                        default: s.kind = RK_NONE;
                    endcase
                end
                4'h1:    s.kind = RK_PEND;
                4'h2:    s.kind = RK_FIQ;
                4'h4:    s.kind = RK_EN;
                4'h5:    s.kind = RK_MSK;
                default: s.kind = RK_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/vic_bank.sv
module vic_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         pend_we_i,
    input  logic         en_we_i,
    input  logic         msk_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] msk_o,
    output logic [W-1:0] act_o
);

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] en;
        logic [W-1:0] msk;
    } bank_st_t;

    bank_st_t     st_d, st_q;
    logic [W-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = pend_we_i ? wdata_i : '0;
        // A held input re-sets its bit in the same edge as a clear.
        st_d.pend = (st_q.pend & ~clr_bits) | src_i;
        if (en_we_i)  st_d.en  = wdata_i;
        if (msk_we_i) st_d.msk = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign msk_o  = st_q.msk;
    assign act_o  = st_q.pend & st_q.en & ~st_q.msk;

    // R2: a raised input is recorded at the next edge
    p_src_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & $past(src_i)) == $past(src_i)));

    // R3: only bits written as one may drop
    p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.pend & $past(st_q.pend & ~clr_bits))
                  == $past(st_q.pend & ~clr_bits)));

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N  = 96,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:1]  act_i,
    output logic [IW-1:0] idx_o,
    output logic          hit_o
);

    // Scan from the top so the lowest index is the final assignment.
    always_comb begin
        idx_o = '0;
        hit_o = 1'b0;
        for (int i = N - 1; i >= 1; i--) begin
            if (act_i[i]) begin
                idx_o = IW'(i);
                hit_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int NMI_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] src_i,
    input  logic                        bus_wr_i,
    input  logic [7:0]                  bus_addr_i,
    input  logic [31:0]                 bus_wdata_i,
    input  logic                        bus_priv_i,
    output logic [31:0]                 bus_rdata_o,
    output logic                        irq_o
);

    import vic_pkg::*;

    localparam int NUM_SRC = NUM_BANKS * BANK_W;
    localparam int IDX_W   = $clog2(NUM_SRC);

    typedef struct packed {
        logic             prot;
        logic [NMI_W-1:0] nmi;
    } ctl_st_t;

    ctl_st_t            st_d, st_q;
    reg_sel_t           sel;
    logic               bank_ok;
    logic               wr_ok;
    logic [NUM_SRC-1:0] act_all;
    logic [IDX_W-1:0]   vec_idx;
    logic               vec_hit;

    logic [BANK_W-1:0] pend_b [NUM_BANKS];
    logic [BANK_W-1:0] en_b   [NUM_BANKS];
    logic [BANK_W-1:0] msk_b  [NUM_BANKS];

    assign sel     = decode_addr(bus_addr_i);
    assign bank_ok = ({30'd0, sel.bank} < 32'(NUM_BANKS));
    assign wr_ok   = bus_wr_i && (!st_q.prot || bus_priv_i);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_b;
        assign hit_b = wr_ok && bank_ok && (sel.bank == 2'(b));

        vic_bank #(.W(BANK_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_i[b*BANK_W +: BANK_W]),
            .pend_we_i (hit_b && sel.kind == RK_PEND),
            .en_we_i   (hit_b && sel.kind == RK_EN),
            .msk_we_i  (hit_b && sel.kind == RK_MSK),
            .wdata_i   (bus_wdata_i[BANK_W-1:0]),
            .pend_o    (pend_b[b]),
            .en_o      (en_b[b]),
            .msk_o     (msk_b[b]),
            .act_o     (act_all[b*BANK_W +: BANK_W])
        );
    end

    vic_prio #(.N(NUM_SRC), .IW(IDX_W)) u_prio (
        .act_i (act_all[NUM_SRC-1:1]),
        .idx_o (vec_idx),
        .hit_o (vec_hit)
    );

    assign irq_o = |act_all;

    always_comb begin
        st_d = st_q;
        if (wr_ok && sel.kind == RK_PROT) st_d.prot = bus_wdata_i[0];
        if (wr_ok && sel.kind == RK_NMI)  st_d.nmi  = bus_wdata_i[NMI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (sel.kind)
            RK_VEC:  bus_rdata_o = vec_hit ? DATA_W'({vec_idx, 2'b00}) : '0;
            RK_PROT: bus_rdata_o = DATA_W'(st_q.prot);
            RK_NMI:  bus_rdata_o = DATA_W'(st_q.nmi);
            default: bus_rdata_o = '0;
        endcase
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_ok && sel.bank == 2'(b)) begin
                if (sel.kind == RK_PEND) bus_rdata_o = DATA_W'(pend_b[b]);
                if (sel.kind == RK_EN)   bus_rdata_o = DATA_W'(en_b[b]);
                if (sel.kind == RK_MSK)  bus_rdata_o = DATA_W'(msk_b[b]);
            end
        end
    end

    // R6: a reported vector names a source that is active right now
    p_vec_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_hit |-> (act_all[vec_idx] && vec_idx != '0));

    // R8: a reported vector always comes with the request line
    p_irq_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_hit |-> irq_o);

    // R7: source 0 alone still raises the line without a vector
    p_src0_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_all[0] |-> irq_o);

    // R9: guarded writes leave the control state untouched
    p_prot_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prot && bus_wr_i && !bus_priv_i) |=> $stable(st_q));

endmodule

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;

    localparam int NB = 3;
    localparam int BW = 32;
    localparam int NS = NB * BW;

    localparam logic [7:0] A_VEC  = 8'h00;
    localparam logic [7:0] A_PROT = 8'h08;
    localparam logic [7:0] A_NMI  = 8'h0c;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_priv = 1'b0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    vic_top #(.NUM_BANKS(NB), .BANK_W(BW), .NMI_W(2)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_priv_i  (bus_priv),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    function automatic logic [7:0] a_pend(input int b); return 8'(8'h10 + 4 * b); endfunction
    function automatic logic [7:0] a_fiq (input int b); return 8'(8'h20 + 4 * b); endfunction
    function automatic logic [7:0] a_en  (input int b); return 8'(8'h40 + 4 * b); endfunction
    function automatic logic [7:0] a_msk (input int b); return 8'(8'h50 + 4 * b); endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        @(negedge clk);
        bus_wr = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input logic [NS-1:0] m);
        @(negedge clk); src = m;
        @(negedge clk); src = '0;
    endtask

    function automatic logic [31:0] vec_of(input int n); return 32'(n * 4); endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_VEC, 0, "R1 vec"); rd(A_PROT, 0, "R1 prot"); rd(A_NMI, 0, "R1 nmi");
        for (int b = 0; b < NB; b++) begin
            rd(a_pend(b), 0, "R1 pend"); rd(a_en(b), 0, "R1 en"); rd(a_msk(b), 0, "R1 msk");
        end
        chk("R1 irq", 32'(irq), 0);

        // R2 latch of source 40 (bank 1 bit 8) while disabled
        pulse(NS'(1) << 40);
        repeat (2) @(negedge clk);
        rd(a_pend(1), 32'h100, "R2 pend latched");
        rd(A_VEC, 0, "R4 disabled vec");
        chk("R4 disabled irq", 32'(irq), 0);

        // R4 enable gating
        wr(a_en(1), 32'h100, 1'b0);
        rd(A_VEC, vec_of(40), "R4 enabled vec");
        chk("R8 irq on", 32'(irq), 1);
        wr(a_en(1), 32'h0, 1'b0);
        rd(A_VEC, 0, "R4 re-disabled vec");
        chk("R4 re-disabled irq", 32'(irq), 0);
        wr(a_en(1), 32'h100, 1'b0);
        rd(A_VEC, vec_of(40), "R4 restored vec");

        // R5 mask gating
        wr(a_msk(1), 32'h100, 1'b0);
        rd(A_VEC, 0, "R5 masked vec");
        chk("R5 masked irq", 32'(irq), 0);
        wr(a_msk(1), 32'h0, 1'b0);
        rd(A_VEC, vec_of(40), "R5 unmasked vec");

        // R3 write-one-to-clear with input held
        @(negedge clk); src = NS'(1) << 40;
        wr(a_pend(1), 32'h100, 1'b0);
        rd(a_pend(1), 32'h100, "R3 held stays");
        @(negedge clk); src = '0;
        wr(a_pend(1), 32'h0, 1'b0);
        rd(a_pend(1), 32'h100, "R3 zero write keeps");
        wr(a_pend(1), 32'hFFFF_FFFF, 1'b0);
        rd(a_pend(1), 32'h0, "R3 cleared");
        chk("R8 irq off", 32'(irq), 0);

        // R6 sweep: raise 95 down to 1, newest lowest always wins
        for (int b = 0; b < NB; b++) wr(a_en(b), 32'hFFFF_FFFF, 1'b0);
        for (int n = NS - 1; n >= 1; n--) begin
            pulse(NS'(1) << n);
            rd(A_VEC, vec_of(n), $sformatf("R6 sweep src %0d", n));
            chk("R8 irq sweep", 32'(irq), 1);
        end
        rd(a_pend(0), 32'hFFFF_FFFE, "R2 bank0 image");
        rd(a_pend(1), 32'hFFFF_FFFF, "R2 bank1 image");
        rd(a_pend(2), 32'hFFFF_FFFF, "R2 bank2 image");

        // R12 drain in ascending order, one cycle per source
        for (int n = 1; n < NS; n++) begin
            rd(A_VEC, vec_of(n), $sformatf("R12 drain src %0d", n));
            wr(a_pend(n / BW), 32'(1) << (n % BW), 1'b0);
        end
        rd(A_VEC, 0, "R6 empty vec");
        chk("R8 irq drained", 32'(irq), 0);

        // R6 mixed pattern across banks
        pulse((NS'(1) << 70) | (NS'(1) << 33) | (NS'(1) << 7));
        rd(A_VEC, vec_of(7), "R6 mix first");
        wr(a_pend(0), 32'h80, 1'b0);
        rd(A_VEC, vec_of(33), "R6 mix second");
        wr(a_pend(1), 32'h2, 1'b0);
        rd(A_VEC, vec_of(70), "R6 mix third");
        wr(a_pend(2), 32'h40, 1'b0);
        rd(A_VEC, 0, "R6 mix empty");

        // R7 source 0
        pulse(NS'(1));
        rd(a_pend(0), 32'h1, "R7 src0 pending");
        rd(A_VEC, 0, "R7 src0 no vector");
        chk("R7 src0 irq", 32'(irq), 1);
        wr(a_pend(0), 32'h1, 1'b0);
        chk("R7 src0 cleared irq", 32'(irq), 0);

        // R9 protection
        wr(A_PROT, 32'h1, 1'b1);
        rd(A_PROT, 32'h1, "R9 prot on");
        wr(a_en(0), 32'h1234, 1'b0);
        rd(a_en(0), 32'hFFFF_FFFF, "R9 unpriv en ignored");
        wr(A_NMI, 32'h1, 1'b0);
        rd(A_NMI, 0, "R9 unpriv nmi ignored");
        wr(A_PROT, 32'h0, 1'b0);
        rd(A_PROT, 32'h1, "R9 unpriv prot ignored");
        pulse(NS'(1) << 3);
        wr(a_pend(0), 32'h8, 1'b0);
        rd(a_pend(0), 32'h8, "R9 unpriv clear ignored");
        wr(a_pend(0), 32'h8, 1'b1);
        rd(a_pend(0), 32'h0, "R9 priv clear");
        wr(a_en(0), 32'h1234, 1'b1);
        rd(a_en(0), 32'h1234, "R9 priv en");
        wr(A_PROT, 32'h0, 1'b1);
        rd(A_PROT, 0, "R9 prot off");
        wr(a_en(0), 32'hA5A5, 1'b0);
        rd(a_en(0), 32'hA5A5, "R9 unpriv when off");

        // R10 external type field
        wr(A_NMI, 32'hFFFF_FFFF, 1'b0);
        rd(A_NMI, 32'h3, "R10 width");
        wr(A_NMI, 32'h2, 1'b0);
        rd(A_NMI, 32'h2, "R10 value");
        wr(A_NMI, 32'h0, 1'b0);
        rd(A_NMI, 32'h0, "R10 default");

        // R11 reserved and read-only views
        wr(a_en(2), 32'hFFFF_FFFF, 1'b0);
        pulse(NS'(1) << 64);
        for (int b = 0; b < NB; b++) rd(a_fiq(b), 0, "R11 fiq view");
        rd(8'h04, 0, "R11 gap 04");
        rd(8'h30, 0, "R11 gap 30");
        rd(8'h60, 0, "R11 gap 60");
        rd(a_pend(3), 0, "R11 bank3 pend");
        wr(a_en(3), 32'h0, 1'b0);
        wr(a_pend(3), 32'hFFFF_FFFF, 1'b0);
        wr(A_VEC, 32'hFFFF_FFFF, 1'b0);
        wr(a_fiq(2), 32'hFFFF_FFFF, 1'b0);
        wr(8'h04, 32'hFFFF_FFFF, 1'b0);
        rd(a_en(2), 32'hFFFF_FFFF, "R11 en2 untouched");
        rd(a_pend(2), 32'h1, "R11 pend2 untouched");
        rd(A_VEC, vec_of(64), "R11 vec untouched");
        rd(A_PROT, 0, "R11 prot untouched");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule